// File: doc/BRIEF.md
# Deflection Side Buffer Stage

This stage wraps a bufferless deflection arbiter in a mesh router so that fewer flits are sent the wrong way. It sits on both sides of the arbiter. On the input side it takes the four flits that arrive in a cycle and lets up to two of them that are addressed to this node leave through a two-wide ejection port. It then fills the empty slots with a flit taken from a small side buffer, then with a flit from the local injection port, and hands the four slots to the arbiter. On the output side it receives the arbiter's four results, each marked as deflected or not. It removes at most one deflected flit per cycle and stores it in the side buffer instead of sending it out on a link.

The side buffer is a four-entry FIFO. When it is full it accepts nothing, and every deflected flit leaves on the port it was given. Its head flit is then marked must-schedule on the slot it takes, which tells the arbiter that this flit may be deflected but must not be held back. The buffer tracks its fill level with a three-state machine. `FILL_EMPTY` moves to `FILL_PART` on a write. `FILL_PART` moves to `FILL_FULL` when a write without a read reaches the depth, and back to `FILL_EMPTY` when a read without a write takes out the last entry. `FILL_FULL` moves to `FILL_PART` on a read. Writes are blocked in `FILL_FULL`. The occupancy count is a status output.

Top module: `defl_side_buffer`

## Requirements
- R1: After reset, occupancy is 0. With no input flits and no injection request, no arbiter slot is valid, nothing ejects and `inj_ack` is low.
- R2: Of the valid input flits with `in_home` set, the two with the lowest slot indices eject. The lowest goes to ejection lane 0 and the next to lane 1. Lane 1 is never used without lane 0. `in_home` has no effect on a slot whose `in_vld` is low.
- R3: A third or fourth home flit in the same cycle does not eject. It goes to the arbiter in its own slot with its data unchanged.
- R4: A valid input flit without `in_home` goes to the arbiter in its own slot with its data unchanged.
- R5: When occupancy is above 0, the buffer head fills the lowest-index slot left empty after ejection and is removed from the buffer at the clock edge. When no slot is empty, the head stays in the buffer.
- R6: A local injection request fills the lowest empty slot not taken by the buffer, and `inj_ack` is high in that cycle. With no such slot, `inj_ack` is low.
- R7: Among the returned flits with both `ret_vld` and `ret_defl` set, the one with the lowest index is dropped from `out_vld` and written into the buffer, as long as occupancy is below 4. All other returned flits pass to the outputs unchanged.
- R8: At occupancy 4 no flit is written, and `out_vld` equals `ret_vld` with the data unchanged.
- R9: Buffered flits are re-injected in the order they were written.
- R10: The slot that takes the buffer head has its `arb_must` bit set only if occupancy was 4 in that cycle. At most one `arb_must` bit is set at a time.
- R11: Occupancy rises by 1 for a write, falls by 1 for a read, stays the same when both or neither happen, and never goes above 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 4 | Input slot valid, one bit per slot |
| in_home | input | 4 | Input flit is addressed to this node |
| in_data | input | 64 | Input flits, slot i in bits [16i+15:16i] |
| ej_vld | output | 2 | Ejection lane valid |
| ej_data | output | 32 | Ejected flits, lane j in bits [16j+15:16j] |
| inj_req | input | 1 | Local node offers a flit |
| inj_data | input | 16 | Local flit offered |
| inj_ack | output | 1 | Local flit accepted this cycle |
| arb_vld | output | 4 | Slot valid toward the arbiter |
| arb_data | output | 64 | Slot flits toward the arbiter |
| arb_must | output | 4 | Slot carries a must-schedule buffer flit |
| ret_vld | input | 4 | Arbiter output valid |
| ret_defl | input | 4 | Arbiter output was deflected |
| ret_data | input | 64 | Arbiter output flits |
| out_vld | output | 4 | Link output valid |
| out_data | output | 64 | Link output flits |
| occupancy | output | 3 | Number of flits in the side buffer |

## Verification
Some properties are checked on every cycle. The ejection lanes fill in order and never carry more flits than there are home flits. No more than one returned flit is taken off the links, and none is taken while the buffer is full. At most one slot is marked must-schedule, and it never lands on a slot that holds a valid non-home input. The fill level stays within bounds, and the buffer is never read when empty or written when full. Other behaviour can only be shown by the bench's scenarios: which home flits win ejection, which free slot the buffer and the injection port each take, that buffered flits come back in the order they were written, that the must-schedule mark appears only for a full buffer, and that a write and a read in the same cycle leave the count unchanged.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
    typedef enum logic [1:0] {
        FILL_EMPTY = 2'd0,
        FILL_PART  = 2'd1,
        FILL_FULL  = 2'd2
    } fill_e;
endpackage

// File: rtl/dsb_eject.sv
module dsb_eject #(
    parameter int NP    = 4,
    parameter int W     = 16,
    parameter int LANES = 2
) (
    input  logic [NP-1:0]      in_vld,
    input  logic [NP-1:0]      in_home,
    input  logic [NP*W-1:0]    in_data,
    output logic [LANES-1:0]   ej_vld,
    output logic [LANES*W-1:0] ej_data,
    output logic [NP-1:0]      keep_vld
);
    localparam int LW = $clog2(LANES + 1);

    always_comb begin
        logic [LW-1:0] taken;
        taken    = '0;
        ej_vld   = '0;
        ej_data  = '0;
        keep_vld = in_vld;
        for (int i = 0; i < NP; i++) begin
            if (in_vld[i] && in_home[i] && (taken < LW'(LANES))) begin
                ej_vld[taken]            = 1'b1;
                ej_data[taken*W +: W]    = in_data[i*W +: W];
                keep_vld[i]              = 1'b0;
                taken                    = taken + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dsb_fill.sv
module dsb_fill #(
    parameter int NP = 4,
    parameter int W  = 16
) (
    input  logic [NP-1:0]   keep_vld,
    input  logic [NP*W-1:0] in_data,
    input  logic            buf_vld,
    input  logic [W-1:0]    buf_flit,
    input  logic            buf_full,
    input  logic            inj_req,
    input  logic [W-1:0]    inj_data,
    output logic [NP-1:0]   arb_vld,
    output logic [NP*W-1:0] arb_data,
    output logic [NP-1:0]   arb_must,
    output logic            pop,
    output logic            inj_ack
);
    always_comb begin
        arb_vld  = keep_vld;
        arb_data = in_data;
        arb_must = '0;
        pop      = 1'b0;
        inj_ack  = 1'b0;
        for (int i = 0; i < NP; i++) begin
            if (!keep_vld[i]) begin
                if (buf_vld && !pop) begin
                    arb_vld[i]         = 1'b1;
                    arb_data[i*W +: W] = buf_flit;
                    arb_must[i]        = buf_full;
                    pop                = 1'b1;
                end else if (inj_req && !inj_ack) begin
                    arb_vld[i]         = 1'b1;
                    arb_data[i*W +: W] = inj_data;
                    inj_ack            = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dsb_fifo.sv
module dsb_fifo
    import dsb_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic          nonempty,
    output logic          full,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    fill_e          state, state_nx;
    logic [W-1:0]   mem [DEPTH];
    logic [AW-1:0]  rd_ptr, wr_ptr;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        state_nx = state;
        unique case (state)
            FILL_EMPTY: if (push) state_nx = FILL_PART;
            FILL_PART: begin
                if (push && !pop && count == CW'(DEPTH - 1))
                    state_nx = FILL_FULL;
                else if (pop && !push && count == CW'(1))
                    state_nx = FILL_EMPTY;
            end
            FILL_FULL:  if (pop) state_nx = FILL_PART;
            default:    state_nx = FILL_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FILL_EMPTY;
        else        state <= state_nx;
    end

    always_comb begin
        full     = (state == FILL_FULL);
        nonempty = (state != FILL_EMPTY);
        head     = mem[rd_ptr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    a_r8_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    a_r11_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> count != '0);
    a_r11_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
endmodule

// File: rtl/defl_side_buffer.sv
module defl_side_buffer #(
    parameter int NP    = 4,
    parameter int W     = 16,
    parameter int DEPTH = 4,
    parameter int LANES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NP-1:0]              in_vld,
    input  logic [NP-1:0]              in_home,
    input  logic [NP*W-1:0]            in_data,
    output logic [LANES-1:0]           ej_vld,
    output logic [LANES*W-1:0]         ej_data,
    input  logic                       inj_req,
    input  logic [W-1:0]               inj_data,
    output logic                       inj_ack,
    output logic [NP-1:0]              arb_vld,
    output logic [NP*W-1:0]            arb_data,
    output logic [NP-1:0]              arb_must,
    input  logic [NP-1:0]              ret_vld,
    input  logic [NP-1:0]              ret_defl,
    input  logic [NP*W-1:0]            ret_data,
    output logic [NP-1:0]              out_vld,
    output logic [NP*W-1:0]            out_data,
    output logic [$clog2(DEPTH+1)-1:0] occupancy
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [NP-1:0] keep_vld;
    logic          buf_vld, buf_full, pop, push;
    logic [W-1:0]  buf_head, push_data;

    dsb_eject #(.NP(NP), .W(W), .LANES(LANES)) u_eject (
        .in_vld(in_vld), .in_home(in_home), .in_data(in_data),
        .ej_vld(ej_vld), .ej_data(ej_data), .keep_vld(keep_vld)
    );

    dsb_fill #(.NP(NP), .W(W)) u_fill (
        .keep_vld(keep_vld), .in_data(in_data),
        .buf_vld(buf_vld), .buf_flit(buf_head), .buf_full(buf_full),
        .inj_req(inj_req), .inj_data(inj_data),
        .arb_vld(arb_vld), .arb_data(arb_data), .arb_must(arb_must),
        .pop(pop), .inj_ack(inj_ack)
    );

    always_comb begin
        push      = 1'b0;
        push_data = '0;
        out_vld   = ret_vld;
        out_data  = ret_data;
        for (int i = 0; i < NP; i++) begin
            if (ret_vld[i] && ret_defl[i] && !push && !buf_full) begin
                push       = 1'b1;
                push_data  = ret_data[i*W +: W];
                out_vld[i] = 1'b0;
            end
        end
    end

    dsb_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_data(push_data), .pop(pop),
        .head(buf_head), .nonempty(buf_vld), .full(buf_full),
        .count(occupancy)
    );

    a_r2_lane_order: assert property (@(posedge clk) disable iff (!rst_n)
        ej_vld[LANES-1] |-> ej_vld[0]);
    a_r2_home_only: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ej_vld) <= $countones(in_vld & in_home));
    a_r7_single_pull: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ret_vld & ~out_vld) <= 1);
    a_r8_full_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy == CW'(DEPTH)) |-> (out_vld == ret_vld));
    a_r10_one_must: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(arb_must));
    a_r5_free_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_must & in_vld & ~in_home) == '0);
endmodule

// File: tb/sim_defl_side_buffer.sv
module sim_defl_side_buffer;
    localparam int NP = 4;
    localparam int W  = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NP-1:0]   in_vld = '0, in_home = '0, ret_vld = '0, ret_defl = '0;
    logic [NP*W-1:0] in_data = '0, ret_data = '0;
    logic            inj_req = 1'b0;
    logic [W-1:0]    inj_data = '0;
    logic [1:0]      ej_vld;
    logic [2*W-1:0]  ej_data;
    logic            inj_ack;
    logic [NP-1:0]   arb_vld, arb_must, out_vld;
    logic [NP*W-1:0] arb_data, out_data;
    logic [2:0]      occupancy;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    defl_side_buffer u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_home(in_home),
        .in_data(in_data), .ej_vld(ej_vld), .ej_data(ej_data),
        .inj_req(inj_req), .inj_data(inj_data), .inj_ack(inj_ack),
        .arb_vld(arb_vld), .arb_data(arb_data), .arb_must(arb_must),
        .ret_vld(ret_vld), .ret_defl(ret_defl), .ret_data(ret_data),
        .out_vld(out_vld), .out_data(out_data), .occupancy(occupancy)
    );

    // each entry: {in_vld, in_home, ejected slot mask, arbiter slot mask}
    localparam logic [15:0] VEC [0:6] = '{
        16'h0000, 16'hF00F, 16'h5441, 16'hFE69, 16'hBB38, 16'h6F60, 16'h8880
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        in_vld = '0; in_home = '0; inj_req = 1'b0;
        ret_vld = '0; ret_defl = '0;
    endtask

    function automatic logic [W-1:0] slot(input logic [NP*W-1:0] v, input int i);
        return v[i*W +: W];
    endfunction

    initial begin
        #4000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(occupancy == 3'd0, "R1 occupancy", 32'(occupancy), 0);
        chk(arb_vld == 4'h0 && ej_vld == 2'b00 && !inj_ack, "R1 idle outputs",
            {arb_vld, 2'b0, ej_vld, 3'b0, inj_ack}, 0);
        rst_n = 1'b1;

        // table: ejection and pass-through with the buffer empty (R2 R3 R4)
        for (int v = 0; v < 7; v++) begin
            logic [3:0] ejm, arbm;
            int lane;
            @(negedge clk);
            in_vld  = VEC[v][15:12];
            in_home = VEC[v][11:8];
            ejm     = VEC[v][7:4];
            arbm    = VEC[v][3:0];
            for (int i = 0; i < NP; i++) in_data[i*W +: W] = W'(16'h1000 * (i + 1) + v);
            #5;
            chk(arb_vld == arbm, "R3 R4 arbiter slots", 32'(arb_vld), 32'(arbm));
            lane = 0;
            for (int i = 0; i < NP; i++) begin
                if (ejm[i]) begin
                    chk(ej_vld[lane] && slot(ej_data, lane) == slot(in_data, i),
                        "R2 ejected flit", 32'(slot(ej_data, lane)), 32'(slot(in_data, i)));
                    lane++;
                end
                if (arbm[i])
                    chk(slot(arb_data, i) == slot(in_data, i), "R4 slot data",
                        32'(slot(arb_data, i)), 32'(slot(in_data, i)));
            end
            chk($countones(ej_vld) == lane, "R2 lane count", 32'(ej_vld), 32'(lane));
        end

        // R6 local injection into lowest free slot
        @(negedge clk);
        idle();
        in_vld = 4'b0101; inj_req = 1'b1; inj_data = 16'hBEEF;
        #5;
        chk(arb_vld == 4'b0111 && slot(arb_data, 1) == 16'hBEEF && inj_ack,
            "R6 inject slot1", {16'(arb_vld), slot(arb_data, 1)}, {16'h7, 16'hBEEF});
        @(negedge clk);
        in_vld = 4'hF;
        #5;
        chk(!inj_ack, "R6 no free slot", 32'(inj_ack), 0);

        // R7 capture of lowest deflected flit
        @(negedge clk);
        idle();
        ret_vld = 4'hF; ret_defl = 4'b0110;
        for (int i = 0; i < NP; i++) ret_data[i*W +: W] = W'(16'h2000 + i);
        #5;
        chk(out_vld == 4'b1101, "R7 pulled slot", 32'(out_vld), 32'hD);
        chk(slot(out_data, 2) == 16'h2002, "R7 others pass", 32'(slot(out_data, 2)), 32'h2002);
        @(negedge clk);
        idle();
        in_vld = 4'b0011; inj_req = 1'b1; inj_data = 16'hCAFE;
        #5;
        chk(occupancy == 3'd1, "R11 count after write", 32'(occupancy), 1);
        chk(arb_vld == 4'hF && slot(arb_data, 2) == 16'h2001 && slot(arb_data, 3) == 16'hCAFE,
            "R5 R6 buffer before injection", {slot(arb_data, 2), slot(arb_data, 3)}, 32'h2001CAFE);
        chk(arb_must == 4'h0 && inj_ack, "R10 no must when not full", 32'(arb_must), 0);

        // fill the buffer with all slots busy
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            idle();
            in_vld = 4'hF; ret_vld = 4'b0001; ret_defl = 4'b0001;
            ret_data[0 +: W] = W'(16'h3000 + k);
        end
        @(negedge clk);
        idle();
        in_vld = 4'hF;
        #5;
        chk(occupancy == 3'd4, "R11 full count", 32'(occupancy), 4);
        chk(arb_must == 4'h0, "R5 no slot no reinject", 32'(arb_must), 0);

        // R8 full: deflected flit leaves on its port
        @(negedge clk);
        ret_vld = 4'b0001; ret_defl = 4'b0001; ret_data[0 +: W] = 16'h4444;
        #5;
        chk(out_vld == 4'b0001 && slot(out_data, 0) == 16'h4444, "R8 full passes",
            {16'(out_vld), slot(out_data, 0)}, {16'h1, 16'h4444});
        @(negedge clk);
        idle();
        in_vld = 4'b1110; inj_req = 1'b1; inj_data = 16'h7777;
        #5;
        chk(occupancy == 3'd4, "R8 no write when full", 32'(occupancy), 4);
        chk(slot(arb_data, 0) == 16'h3000, "R9 oldest first", 32'(slot(arb_data, 0)), 32'h3000);
        chk(arb_must == 4'b0001, "R10 must when full", 32'(arb_must), 1);
        chk(!inj_ack, "R6 buffer ahead of injection", 32'(inj_ack), 0);

        @(negedge clk);
        idle();
        #5;
        chk(slot(arb_data, 0) == 16'h3001 && arb_must == 4'h0, "R9 R10 next head",
            {slot(arb_data, 0), 16'(arb_must)}, {16'h3001, 16'h0});
        // simultaneous write and read
        @(negedge clk);
        ret_vld = 4'b0010; ret_defl = 4'b0010; ret_data[W +: W] = 16'h5555;
        #5;
        chk(occupancy == 3'd2 && slot(arb_data, 0) == 16'h3002, "R9 third head",
            {16'(occupancy), slot(arb_data, 0)}, {16'h2, 16'h3002});
        @(negedge clk);
        idle();
        #5;
        chk(occupancy == 3'd2, "R11 write with read", 32'(occupancy), 2);
        chk(slot(arb_data, 0) == 16'h3003, "R9 fourth head", 32'(slot(arb_data, 0)), 32'h3003);
        @(negedge clk);
        #5;
        chk(slot(arb_data, 0) == 16'h5555, "R9 late write last", 32'(slot(arb_data, 0)), 32'h5555);
        @(negedge clk);
        #5;
        chk(occupancy == 3'd0 && arb_vld == 4'h0, "R11 drained",
            {16'(occupancy), 16'(arb_vld)}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule